// File: doc/BRIEF.md
# Vectored Interrupt Controller with Debug Protection

This block collects a set of interrupt request lines and turns them into two active-low lines toward a processor core. One line is the normal interrupt and the other is the fast interrupt. Each source has its own vector word, a priority and a trigger mode, which is either a level or a rising edge. Software reads a vector register to fetch the handler address of the winning source. That fetch acknowledges the interrupt: the source's priority is pushed onto a nesting stack, so only a strictly higher priority can interrupt the running handler. An end-of-interrupt write pops the stack again.

Source 0 always belongs to the fast interrupt. Any other source can also be moved onto the fast line by a per-source force bit. Forced sources never take part in normal arbitration. They are also never cleared as a side effect of a vector fetch, so software must clear them explicitly, and a second edge is not lost.

A protect bit makes the normal vector fetch free of side effects, so a debugger can inspect the register file safely. In this mode the acknowledge happens only when software writes the normal vector register.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, nirq and nfiq are 1. The mask (0x84), pending (0x83), status (0x82) and spurious (0x89) registers all read 0, and the priority stack is empty.
- R2: When config bit 8 of a source is 1 (config at 0x40+i, priority in bits [PW-1:0]), the source is edge-triggered. A rising input sets its pending bit, visible from the next cycle, and the bit holds until it is cleared. When config bit 8 is 0, the pending bit follows the input.
- R3: Writing 1s to 0x85 sets mask bits and writing 1s to 0x86 clears them. A pending source whose mask bit is clear drives neither nirq nor nfiq and is never selected.
- R4: Among the enabled, pending sources that are not fast, the one with the highest priority wins. On equal priority, the lowest-numbered source wins.
- R5: nirq is 0 exactly when a winner exists and either the stack is empty or the winner's priority is strictly above the top of the stack. The stack holds 2^PW entries and never grows past that.
- R6: Reading 0x80 returns the vector word of the winner (vector of source i at address i) when nirq would be 0. Otherwise it returns the spurious register.
- R7: An acknowledge pushes the winner's priority and number onto the stack and clears the winner's edge-pending bit. Status then reads bit 8 = 1 and bits [7:0] = the number on top of the stack.
- R8: Writing 0x88 pops one stack entry and restores the previous level. On an empty stack the write has no effect.
- R9: Writing bit 0 of 0x8A turns protect mode on. In that mode a read of 0x80 returns the vector with no side effect, and any write to 0x80 performs the acknowledge.
- R10: The fast set is source 0 plus every source whose force bit is set. Writing 1s to 0x8B sets force bits and writing 1s to 0x8C clears them; 0x8D reads the fast set. nfiq is 0 exactly when an enabled member of the fast set is pending.
- R11: Reading 0x81 returns source 0's vector. It clears source 0's edge-pending bit only when no source 1..N-1 is forced.
- R12: A forced source is excluded from normal arbitration and is never cleared by a vector fetch. Writing 1s to 0x87 clears the edge-pending bits of any sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NSRC | Interrupt request inputs |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects on the clock edge) |
| addr | input | AW | Register word address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for the current address |
| nirq | output | 1 | Normal interrupt, active low |
| nfiq | output | 1 | Fast interrupt, active low |

## Verification
The bench builds the controller with eight sources and the default 3-bit priority. With that setting every mask, pending and force pattern reads back as a short hex word. Two sources at the same priority bring the tie rule within reach, and a third at a higher level shows nesting and restore across end-of-interrupt. Forcing one source onto the fast line while source 0 is also pending covers the cases where a fast vector read must leave pending bits alone.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam logic [7:0] A_VEC_BASE = 8'h00;
  localparam logic [7:0] A_CFG_BASE = 8'h40;
  localparam logic [7:0] A_IVR      = 8'h80;
  localparam logic [7:0] A_FVR      = 8'h81;
  localparam logic [7:0] A_STAT     = 8'h82;
  localparam logic [7:0] A_PEND     = 8'h83;
  localparam logic [7:0] A_MASK     = 8'h84;
  localparam logic [7:0] A_EN       = 8'h85;
  localparam logic [7:0] A_DIS      = 8'h86;
  localparam logic [7:0] A_CLR      = 8'h87;
  localparam logic [7:0] A_EOI      = 8'h88;
  localparam logic [7:0] A_SPUR     = 8'h89;
  localparam logic [7:0] A_DBG      = 8'h8A;
  localparam logic [7:0] A_FFEN     = 8'h8B;
  localparam logic [7:0] A_FFDIS    = 8'h8C;
  localparam logic [7:0] A_FFST     = 8'h8D;

  // a candidate may interrupt when nothing is stacked or it strictly outranks the top
  function automatic logic outranks(logic [7:0] cand_p, logic [7:0] top_p, logic top_v);
    return !top_v || (cand_p > top_p);
  endfunction
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic [NSRC-1:0] edge_mode,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] pending
);
  logic [NSRC-1:0] prev_q;
  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] rise;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign rise[g] = src_in[g] & ~prev_q[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_q[g] <= 1'b0;
        pend_q[g] <= 1'b0;
      end else begin
        prev_q[g] <= src_in[g];
        // a fresh edge wins over a clear in the same cycle
        pend_q[g] <= rise[g] | (pend_q[g] & ~clr[g]);
      end
    end

    assign pending[g] = edge_mode[g] ? pend_q[g] : src_in[g];

    p_edge_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[g] && !clr[g]) |=> pend_q[g]);
    p_edge_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (src_in[g] && !prev_q[g]) |=> pend_q[g]);
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NSRC = 32,
  parameter int PW   = 3,
  parameter int IDW  = 5
) (
  input  logic [NSRC-1:0]    cand,
  input  logic [NSRC*PW-1:0] prio_flat,
  output logic               found,
  output logic [IDW-1:0]     best_id,
  output logic [PW-1:0]      best_prio
);
  always_comb begin
    found     = 1'b0;
    best_id   = '0;
    best_prio = '0;
    for (int i = 0; i < NSRC; i++) begin
      // strict compare keeps the lowest index on ties
      if (cand[i] && (!found || prio_flat[i*PW +: PW] > best_prio)) begin
        found     = 1'b1;
        best_id   = IDW'(i);
        best_prio = prio_flat[i*PW +: PW];
      end
    end
  end

  always_comb begin
    if (found) p_pick_valid_r4: assert (cand[best_id]);
    if (!found) p_pick_none_r4: assert (cand == '0);
  end
endmodule

// File: rtl/irq_prio_stack.sv
module irq_prio_stack #(
  parameter int PW    = 3,
  parameter int IDW   = 5,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic                         pop,
  input  logic [PW-1:0]                push_prio,
  input  logic [IDW-1:0]               push_id,
  output logic                         top_valid,
  output logic [PW-1:0]                top_prio,
  output logic [IDW-1:0]               top_id,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PW-1:0]  prio_q [DEPTH];
  logic [IDW-1:0] id_q   [DEPTH];
  logic [CW-1:0]  cnt_q;
  logic [IW-1:0]  top_idx;

  assign top_idx   = IW'(cnt_q - CW'(1));
  assign top_valid = (cnt_q != '0);
  assign top_prio  = top_valid ? prio_q[top_idx] : '0;
  assign top_id    = top_valid ? id_q[top_idx] : '0;
  assign level     = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        prio_q[i] <= '0;
        id_q[i]   <= '0;
      end
    end else if (push && cnt_q < CW'(DEPTH)) begin
      prio_q[IW'(cnt_q)] <= push_prio;
      id_q[IW'(cnt_q)]   <= push_id;
      cnt_q              <= cnt_q + CW'(1);
    end else if (pop && top_valid) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q < CW'(DEPTH)));
  p_eoi_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && top_valid) |=> (cnt_q == $past(cnt_q) - CW'(1)));
  p_eoi_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !top_valid) |=> (cnt_q == '0));
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int PRIO_W = 3,
  parameter int AW     = 8,
  parameter int DW     = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic            nirq,
  output logic            nfiq
);
  localparam int IDW   = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int DEPTH = 2 ** PRIO_W;
  localparam int CW    = $clog2(DEPTH + 1);

  logic [DW-1:0]     vec_q  [NSRC];
  logic [PRIO_W-1:0] prio_q [NSRC];
  logic [NSRC-1:0]   edge_q, mask_q, ff_q;
  logic [DW-1:0]     spur_q;
  logic              protect_q;

  logic [NSRC*PRIO_W-1:0] prio_flat;
  logic [NSRC-1:0] pending, fast, cand, clr_vec;
  logic            found, irq_ok, fiq_any;
  logic [IDW-1:0]  best_id, top_id;
  logic [PRIO_W-1:0] best_prio, top_prio;
  logic            top_valid;
  logic [CW-1:0]   stk_level;

  // named internal events
  logic ivr_rd, ivr_wr, fvr_rd, ack_evt, eoi_evt, is_vec, is_cfg;
  logic [AW-1:0] cfg_off;

  assign ivr_rd  = rd_en && addr == AW'(A_IVR);
  assign ivr_wr  = wr_en && addr == AW'(A_IVR);
  assign fvr_rd  = rd_en && addr == AW'(A_FVR);
  assign eoi_evt = wr_en && addr == AW'(A_EOI);
  assign ack_evt = (protect_q ? ivr_wr : ivr_rd) && irq_ok;
  assign is_vec  = addr >= AW'(A_VEC_BASE) && addr < AW'(A_VEC_BASE) + AW'(NSRC);
  assign is_cfg  = addr >= AW'(A_CFG_BASE) && addr < AW'(A_CFG_BASE) + AW'(NSRC);
  assign cfg_off = addr - AW'(A_CFG_BASE);

  for (genvar g = 0; g < NSRC; g++) begin : g_flat
    assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q[g];
  end

  assign fast    = ff_q | NSRC'(1);
  assign cand    = pending & mask_q & ~fast;
  assign fiq_any = |(pending & mask_q & fast);
  assign irq_ok  = found && outranks(8'(best_prio), 8'(top_prio), top_valid);
  assign nirq    = ~irq_ok;
  assign nfiq    = ~fiq_any;

  always_comb begin
    clr_vec = '0;
    if (wr_en && addr == AW'(A_CLR)) clr_vec = wdata[NSRC-1:0];
    if (ack_evt) clr_vec = clr_vec | (NSRC'(1) << best_id);
    if (fvr_rd && ff_q[NSRC-1:1] == '0) clr_vec[0] = 1'b1;
  end

  irq_src_bank #(.NSRC(NSRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .edge_mode(edge_q),
    .clr(clr_vec), .pending(pending));

  irq_prio_pick #(.NSRC(NSRC), .PW(PRIO_W), .IDW(IDW)) u_pick (
    .cand(cand), .prio_flat(prio_flat), .found(found),
    .best_id(best_id), .best_prio(best_prio));

  irq_prio_stack #(.PW(PRIO_W), .IDW(IDW), .DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(ack_evt), .pop(eoi_evt),
    .push_prio(best_prio), .push_id(best_id), .top_valid(top_valid),
    .top_prio(top_prio), .top_id(top_id), .level(stk_level));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) begin
        vec_q[i]  <= '0;
        prio_q[i] <= '0;
      end
      edge_q    <= '0;
      mask_q    <= '0;
      ff_q      <= '0;
      spur_q    <= '0;
      protect_q <= 1'b0;
    end else if (wr_en) begin
      if (is_vec) vec_q[addr[IDW-1:0]] <= wdata;
      if (is_cfg) begin
        prio_q[cfg_off[IDW-1:0]] <= wdata[PRIO_W-1:0];
        edge_q[cfg_off[IDW-1:0]] <= wdata[8];
      end
      case (addr)
        AW'(A_EN):    mask_q    <= mask_q | wdata[NSRC-1:0];
        AW'(A_DIS):   mask_q    <= mask_q & ~wdata[NSRC-1:0];
        AW'(A_FFEN):  ff_q      <= ff_q | wdata[NSRC-1:0];
        AW'(A_FFDIS): ff_q      <= ff_q & ~wdata[NSRC-1:0];
        AW'(A_SPUR):  spur_q    <= wdata;
        AW'(A_DBG):   protect_q <= wdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    if (is_vec) rdata = vec_q[addr[IDW-1:0]];
    else if (is_cfg) begin
      rdata[PRIO_W-1:0] = prio_q[cfg_off[IDW-1:0]];
      rdata[8]          = edge_q[cfg_off[IDW-1:0]];
    end else begin
      case (addr)
        AW'(A_IVR):  rdata = irq_ok ? vec_q[best_id] : spur_q;
        AW'(A_FVR):  rdata = vec_q[0];
        AW'(A_STAT): begin
          rdata[IDW-1:0] = top_id;
          rdata[8]       = top_valid;
        end
        AW'(A_PEND): rdata[NSRC-1:0] = pending;
        AW'(A_MASK): rdata[NSRC-1:0] = mask_q;
        AW'(A_SPUR): rdata = spur_q;
        AW'(A_DBG):  rdata[0] = protect_q;
        AW'(A_FFST): rdata[NSRC-1:0] = fast;
        default: ;
      endcase
    end
  end

  p_ack_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_evt |=> (stk_level == $past(stk_level) + CW'(1)));
  p_protect_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (protect_q && ivr_rd && !wr_en) |=> $stable(stk_level));
  p_fvr_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fvr_rd && !wr_en && ff_q[NSRC-1:1] != '0 && edge_q[0] && pending[0]) |=> pending[0]);
  p_fast_excluded_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ff_q[best_id] && best_id != '0) |-> !found);
endmodule

// File: tb/irq_vec_ctrl_tb.sv
module irq_vec_ctrl_tb;
  localparam int N = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] src = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic nirq, nfiq;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  irq_vec_ctrl #(.NSRC(N), .PRIO_W(3), .AW(8), .DW(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_in(src), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .nirq(nirq), .nfiq(nfiq));

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic rchk(string req, string what, logic [7:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, what, d, exp);
  endtask

  task automatic pins(string req, logic ei, logic ef);
    @(negedge clk); #1;
    chk(req, "nirq", {31'b0, nirq}, {31'b0, ei});
    chk(req, "nfiq", {31'b0, nfiq}, {31'b0, ef});
  endtask

  task automatic pulse(logic [N-1:0] m);
    @(negedge clk); src = src | m;
    @(negedge clk); src = src & ~m;
  endtask

  task automatic setup(int i, int p, bit e, logic [31:0] v);
    wr(8'(i), v);
    wr(8'h40 + 8'(i), {23'b0, e, 5'b0, 3'(p)});
  endtask

  task automatic t_reset;
    pins("R1", 1, 1);
    rchk("R1", "mask", 8'h84, 0);
    rchk("R1", "pend", 8'h83, 0);
    rchk("R1", "stat", 8'h82, 0);
    rchk("R1", "spur", 8'h89, 0);
    rchk("R6", "ivr idle", 8'h80, 0);
    wr(8'h89, 32'hDEAD);
    rchk("R6", "ivr spurious", 8'h80, 32'hDEAD);
  endtask

  task automatic t_basic;
    setup(3, 2, 1, 32'h300);
    wr(8'h85, 32'h08);
    rchk("R3", "mask", 8'h84, 32'h08);
    pins("R5", 1, 1);
    pulse(8'h08);
    rchk("R2", "edge pend", 8'h83, 32'h08);
    pins("R5", 0, 1);
    rchk("R6", "ivr vec", 8'h80, 32'h300);
    rchk("R7", "auto clear", 8'h83, 0);
    rchk("R7", "stat", 8'h82, 32'h103);
    pins("R7", 1, 1);
    wr(8'h88, 0);
    rchk("R8", "stat pop", 8'h82, 0);
    wr(8'h88, 0);
    rchk("R8", "empty eoi", 8'h82, 0);
  endtask

  task automatic t_level;
    setup(2, 1, 0, 32'h200);
    wr(8'h85, 32'h04);
    @(negedge clk); src[2] = 1'b1;
    pins("R2", 0, 1);
    rchk("R6", "ivr level", 8'h80, 32'h200);
    rchk("R2", "level stays", 8'h83, 32'h04);
    pins("R5", 1, 1);
    @(negedge clk); src[2] = 1'b0;
    rchk("R2", "level drops", 8'h83, 0);
    wr(8'h88, 0);
  endtask

  task automatic t_prio;
    setup(4, 3, 1, 32'h400);
    setup(5, 3, 1, 32'h500);
    setup(6, 6, 1, 32'h600);
    wr(8'h85, 32'h70);
    pulse(8'h30);
    rchk("R4", "tie low index", 8'h80, 32'h400);
    rchk("R7", "stat4", 8'h82, 32'h104);
    pins("R5", 1, 1);
    pulse(8'h40);
    pins("R5", 0, 1);
    rchk("R4", "higher nests", 8'h80, 32'h600);
    rchk("R7", "stat6", 8'h82, 32'h106);
    wr(8'h88, 0);
    rchk("R8", "restore", 8'h82, 32'h104);
    pins("R5", 1, 1);
    wr(8'h88, 0);
    pins("R5", 0, 1);
    rchk("R4", "waiting src", 8'h80, 32'h500);
    wr(8'h88, 0);
    wr(8'h86, 32'h70);
  endtask

  task automatic t_disable;
    wr(8'h86, 32'h08);
    pulse(8'h08);
    rchk("R3", "pend masked", 8'h83, 32'h08);
    pins("R3", 1, 1);
    rchk("R3", "ivr masked", 8'h80, 32'hDEAD);
    wr(8'h85, 32'h08);
    pins("R3", 0, 1);
    wr(8'h87, 32'h08);
    rchk("R12", "clear cmd", 8'h83, 0);
    pins("R12", 1, 1);
  endtask

  task automatic t_protect;
    wr(8'h8A, 1);
    pulse(8'h08);
    rchk("R9", "read1", 8'h80, 32'h300);
    rchk("R9", "read2", 8'h80, 32'h300);
    rchk("R9", "pend kept", 8'h83, 32'h08);
    rchk("R9", "stat kept", 8'h82, 0);
    pins("R9", 0, 1);
    wr(8'h80, 32'h1234);
    rchk("R9", "write acks", 8'h82, 32'h103);
    rchk("R9", "write clears", 8'h83, 0);
    pins("R9", 1, 1);
    wr(8'h88, 0);
    wr(8'h8A, 0);
  endtask

  task automatic t_fiq;
    setup(0, 0, 1, 32'hF00);
    wr(8'h85, 32'h01);
    pulse(8'h01);
    pins("R10", 1, 0);
    rchk("R11", "fvr", 8'h81, 32'hF00);
    rchk("R11", "fvr clears", 8'h83, 0);
    pins("R10", 1, 1);
  endtask

  task automatic t_force;
    wr(8'h8B, 32'h40);
    rchk("R10", "fast set", 8'h8D, 32'h41);
    wr(8'h85, 32'h40);
    pulse(8'h40);
    pins("R10", 1, 0);
    rchk("R12", "ivr skips forced", 8'h80, 32'hDEAD);
    rchk("R12", "forced kept", 8'h83, 32'h40);
    rchk("R11", "fvr forced", 8'h81, 32'hF00);
    rchk("R11", "forced kept fvr", 8'h83, 32'h40);
    pulse(8'h01);
    rchk("R11", "fvr src0", 8'h81, 32'hF00);
    rchk("R11", "src0 kept", 8'h83, 32'h41);
    wr(8'h87, 32'h41);
    rchk("R12", "clear both", 8'h83, 0);
    pins("R10", 1, 1);
    wr(8'h8C, 32'h40);
    rchk("R10", "unforce", 8'h8D, 32'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_basic;
    t_level;
    t_prio;
    t_disable;
    t_protect;
    t_fiq;
    t_force;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule